// File: doc/BRIEF.md
# Level-Shifted Carrier Sine PWM Modulator

This block drives one phase leg of a diode-clamped multilevel inverter with 5 or 7 output levels. The level count is fixed at elaboration. A phase accumulator and a parabolic sine shaper produce a digital reference. That reference is compared every clock against a vertical stack of triangular carriers, all derived from one shared up/down ramp. The number of carriers lying below the reference is the output level. The level is decoded into a sliding window of switch commands for the leg.

A run-time mode input selects how the carriers are phased against each other. In the in-phase arrangement every band uses the same ramp. In the opposed arrangement the bands above and below the midline are mirrored against each other. In the alternating arrangement every second band is mirrored. A new mode is picked up only at a carrier valley, so a carrier period is never cut short.

The control inputs (mode, modulation index, reference step, carrier divider) are plain levels sampled every clock. No stream traffic passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `spwm_modulator`

## Requirements
- R1: With N = LEVELS-1 carriers, band k (k = 0 at the bottom) has value k·BAND + c_k, where BAND = 2^CW. Every c_k is taken from one shared ramp that counts 0,1,…,BAND-1 and back down to 0. The ramp moves one step on each tick, and a tick occurs when an internal divider counter equals car_div_i. The divider is cleared on a tick, otherwise it increments and wraps.
- R2: With mode_i = 0 (in-phase), or with the reserved code 3, every band uses c_k = ramp.
- R3: With mode_i = 1 (opposed), bands with k ≥ N/2 use the ramp and bands with k < N/2 use BAND-1-ramp.
- R4: With mode_i = 2 (alternating), even bands use BAND-1-ramp and odd bands use the ramp.
- R5: The reference is registered from the phase accumulator, which adds step_i every clock, modulo 2^PH_W.
  - The top SH_W phase bits are split into a sign (their MSB) and x (the rest).
  - The hump is hump = x·(2^(SH_W-1)-x) >> (2·SH_W-12).
  - The deviation is dev = (hump·mod_idx_i·HALF) >> (MA_W+8), with HALF = N·BAND/2.
  - The reference is HALF-dev when the sign is set and HALF+dev otherwise.
- R6: level_o is a register loaded each clock with the count of bands whose value is strictly below the current reference.
- R7: For j = 1…N, gate_o bit j-1 (upper switch j, with j = 1 nearest the positive rail) is on exactly when level_o + j > N. At level N all upper switches are on; at level 0 all lower switches are on.
- R8: gate_o bit N+j-1 (lower switch j) is always the complement of bit j-1, so exactly N of the 2N gates are on.
- R9: mode_i is captured only on a tick at which the ramp is 0. The captured mode applies to comparisons from the next clock on.
- R10: After reset the phase, ramp, divider and level are 0, the ramp is rising, the mode is in-phase and the reference is HALF. gate_o is therefore all lower switches on.
- R11: With mod_idx_i = 0 the level stays at N/2 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Carrier arrangement: 0 in-phase, 1 opposed, 2 alternating, 3 as 0 |
| mod_idx_i | input | MA_W | Modulation index, unsigned fraction of 2^MA_W |
| step_i | input | PH_W | Phase increment per clock (reference frequency) |
| car_div_i | input | DIV_W | Clocks per ramp step, minus one |
| gate_o | output | 2·(LEVELS-1) | Upper switches in low half, complements in high half |
| level_o | output | clog2(LEVELS) | Current output level, 0 = most negative |

## Verification
Two functions can land in the same clock: the mode capture at a ramp valley and the comparison that produces the level. The new mode must not reach the comparator before the next cycle. The bench provokes this by tracking its own model of the ramp and switching mode_i exactly on the valley tick, and also at arbitrary points mid-period. It then checks that every level in the following cycles matches a comparison made with the mode that should have been in force.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    ARR_PD   = 2'd0,
    ARR_POD  = 2'd1,
    ARR_APOD = 2'd2,
    ARR_RSV  = 2'd3
  } carrier_arr_e;
endpackage

// File: rtl/spwm_ref_gen.sv
// Phase accumulator followed by a parabolic sine shaper and an index scaler.
module spwm_ref_gen #(
  parameter int PH_W  = 16,
  parameter int SH_W  = 10,
  parameter int MA_W  = 8,
  parameter int REF_W = 9,
  parameter int HALF  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  step_i,
  input  logic [MA_W-1:0]  ma_i,
  output logic [REF_W-1:0] ref_o
);
  localparam int HP    = 2 ** (SH_W - 1);
  localparam int SHIFT = 2 * SH_W - 12;

  logic [PH_W-1:0]  phase_q;
  logic [SH_W-1:0]  top_bits;
  logic             neg;
  logic [SH_W-2:0]  x;
  logic [31:0]      hump;
  logic [31:0]      dev;
  logic [REF_W-1:0] ref_q;

  assign top_bits = phase_q[PH_W-1 -: SH_W];
  assign neg      = top_bits[SH_W-1];
  assign x        = top_bits[SH_W-2:0];

  always_comb begin
    hump = (32'(x) * (32'(HP) - 32'(x))) >> SHIFT;
    dev  = (hump * 32'(ma_i) * 32'(HALF)) >> (MA_W + 8);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ref_q   <= REF_W'(HALF);
    end else begin
      phase_q <= phase_q + step_i;
      ref_q   <= neg ? REF_W'(32'(HALF) - dev) : REF_W'(32'(HALF) + dev);
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/spwm_carrier_tb.sv
// Shared triangular ramp with prescaler; the mode is latched at the valley.
module spwm_carrier_tb import spwm_pkg::*; #(
  parameter int CW    = 6,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       mode_i,
  output logic [CW-1:0]    ramp_o,
  output carrier_arr_e     mode_o
);
  localparam logic [CW-1:0] TOP = '1;

  logic [DIV_W-1:0] div_q;
  logic [CW-1:0]    ramp_q;
  logic             up_q;
  carrier_arr_e     mode_q;
  logic             tick;

  assign tick = (div_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ramp_q <= '0;
      up_q   <= 1'b1;
      mode_q <= ARR_PD;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (ramp_q == '0) mode_q <= carrier_arr_e'(mode_i);
        if (up_q) begin
          if (ramp_q == TOP) begin
            up_q   <= 1'b0;
            ramp_q <= TOP - 1'b1;
          end else begin
            ramp_q <= ramp_q + 1'b1;
          end
        end else begin
          if (ramp_q == '0) begin
            up_q   <= 1'b1;
            ramp_q <= CW'(1);
          end else begin
            ramp_q <= ramp_q - 1'b1;
          end
        end
      end
    end
  end

  assign ramp_o = ramp_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/spwm_level_cmp.sv
// One comparator per carrier band; the count of bands below the reference is registered.
module spwm_level_cmp import spwm_pkg::*; #(
  parameter int N     = 4,
  parameter int CW    = 6,
  parameter int REF_W = 9,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    ramp_i,
  input  carrier_arr_e     mode_i,
  input  logic [REF_W-1:0] ref_i,
  output logic [LVL_W-1:0] level_o
);
  localparam int BAND = 2 ** CW;
  localparam logic [CW-1:0] TOP = '1;

  logic [N-1:0]     below;
  logic [LVL_W-1:0] cnt;
  logic [LVL_W-1:0] lvl_q;

  for (genvar k = 0; k < N; k++) begin : g_band
    logic             flip;
    logic [CW-1:0]    c;
    logic [REF_W-1:0] val;
    always_comb begin
      case (mode_i)
        ARR_POD:  flip = (k < N / 2);
        ARR_APOD: flip = ((k % 2) == 0);
        default:  flip = 1'b0;
      endcase
    end
    assign c        = flip ? (TOP - ramp_i) : ramp_i;
    assign val      = REF_W'(k * BAND) + REF_W'(c);
    assign below[k] = (val < ref_i);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + LVL_W'(below[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= cnt;
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/spwm_gate_dec.sv
// Level to sliding switch window: upper switch j on when level + j > N.
module spwm_gate_dec #(
  parameter int N     = 4,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [2*N-1:0]   gate_o
);
  logic [N-1:0] upper;

  for (genvar j = 1; j <= N; j++) begin : g_sw
    assign upper[j-1] = (int'(level_i) + j > N);
  end

  assign gate_o = {~upper, upper};
endmodule

// File: rtl/spwm_modulator.sv
module spwm_modulator import spwm_pkg::*; #(
  parameter int LEVELS = 5,
  parameter int PH_W   = 16,
  parameter int SH_W   = 10,
  parameter int MA_W   = 8,
  parameter int CW     = 6,
  parameter int DIV_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode_i,
  input  logic [MA_W-1:0]               mod_idx_i,
  input  logic [PH_W-1:0]               step_i,
  input  logic [DIV_W-1:0]              car_div_i,
  output logic [2*(LEVELS-1)-1:0]       gate_o,
  output logic [$clog2(LEVELS)-1:0]     level_o
);
  localparam int N     = LEVELS - 1;
  localparam int BAND  = 2 ** CW;
  localparam int RANGE = N * BAND;
  localparam int HALF  = RANGE / 2;
  localparam int REF_W = $clog2(RANGE + 1);
  localparam int LVL_W = $clog2(LEVELS);

  logic [REF_W-1:0] ref_w;
  logic [CW-1:0]    ramp_w;
  carrier_arr_e     mode_w;

  spwm_ref_gen #(
    .PH_W(PH_W), .SH_W(SH_W), .MA_W(MA_W), .REF_W(REF_W), .HALF(HALF)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .ma_i(mod_idx_i), .ref_o(ref_w)
  );

  spwm_carrier_tb #(.CW(CW), .DIV_W(DIV_W)) u_car (
    .clk(clk), .rst_n(rst_n), .div_i(car_div_i), .mode_i(mode_i),
    .ramp_o(ramp_w), .mode_o(mode_w)
  );

  spwm_level_cmp #(.N(N), .CW(CW), .REF_W(REF_W), .LVL_W(LVL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ramp_i(ramp_w), .mode_i(mode_w),
    .ref_i(ref_w), .level_o(level_o)
  );

  spwm_gate_dec #(.N(N), .LVL_W(LVL_W)) u_dec (
    .level_i(level_o), .gate_o(gate_o)
  );
endmodule

// File: rtl/spwm_modulator_chk.sv
module spwm_modulator_chk #(
  parameter int N     = 4,
  parameter int CW    = 6,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2*N-1:0]   gate_i,
  input logic [LVL_W-1:0] level_i,
  input logic [CW-1:0]    ramp_i,
  input logic [1:0]       mode_i
);
  // R8: each lower gate complements its upper gate
  a_r8_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i[2*N-1:N] == ~gate_i[N-1:0]);

  // R8: exactly N switches conduct
  a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_i) == N);

  // R7: number of upper switches on equals the level
  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_i[N-1:0]) == int'(level_i));

  // R7: the switch nearest the positive rail only conducts with the whole upper set
  a_r7_top_full: assert property (@(posedge clk) disable iff (!rst_n)
    gate_i[0] |-> (&gate_i[N-1:0]));

  // R6: level never exceeds the carrier count
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_i) <= N);

  // R1: the shared ramp moves by at most one step per clock
  a_r1_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_i != $past(ramp_i)) |->
      (ramp_i == $past(ramp_i) + 1'b1 || ramp_i == $past(ramp_i) - 1'b1));

  // R9: the active mode changes only as the ramp leaves its valley
  a_r9_mode_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != $past(mode_i)) |-> ($past(ramp_i) == '0 && ramp_i == CW'(1)));
endmodule

bind spwm_modulator spwm_modulator_chk #(.N(N), .CW(CW), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_i(gate_o), .level_i(level_o),
  .ramp_i(ramp_w), .mode_i(mode_w)
);

// File: tb/spwm_modulator_bench.sv
`timescale 1ns/1ps
module spwm_modulator_bench;
  localparam int LEVELS = 5;
  localparam int PH_W   = 16;
  localparam int SH_W   = 10;
  localparam int MA_W   = 8;
  localparam int CW     = 6;
  localparam int DIV_W  = 8;
  localparam int N      = LEVELS - 1;
  localparam int BAND   = 2 ** CW;
  localparam int TOP    = BAND - 1;
  localparam int HALF   = N * BAND / 2;
  localparam int LVL_W  = $clog2(LEVELS);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          mode = '0;
  logic [MA_W-1:0]     ma = '0;
  logic [PH_W-1:0]     step = '0;
  logic [DIV_W-1:0]    cdiv = '0;
  logic [2*N-1:0]      gate;
  logic [LVL_W-1:0]    level;

  int n_chk = 0;
  int n_err = 0;
  bit chk_en = 1'b0;
  int seen_max = 0;
  int seen_min = N;

  always #4 clk = ~clk;

  spwm_modulator #(
    .LEVELS(LEVELS), .PH_W(PH_W), .SH_W(SH_W), .MA_W(MA_W), .CW(CW), .DIV_W(DIV_W)
  ) u_spwm_modulator (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .mod_idx_i(ma), .step_i(step),
    .car_div_i(cdiv), .gate_o(gate), .level_o(level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R5 reference from the requirement formula
  function automatic int exp_ref(input int ph, input int mi);
    int tb   = (ph >> (PH_W - SH_W)) & ((1 << SH_W) - 1);
    int x    = tb & ((1 << (SH_W - 1)) - 1);
    int hump = (x * ((1 << (SH_W - 1)) - x)) >> (2 * SH_W - 12);
    int dev  = (hump * mi * HALF) >> (MA_W + 8);
    return ((tb >> (SH_W - 1)) != 0) ? HALF - dev : HALF + dev;
  endfunction

  // R1..R4 band values, R6 count
  function automatic int exp_level(input int r, input int rp, input int md);
    int cnt = 0;
    for (int k = 0; k < N; k++) begin
      bit inv;
      if (md == 1)      inv = (k < N / 2);
      else if (md == 2) inv = (k % 2 == 0);
      else              inv = 1'b0;
      if (k * BAND + (inv ? TOP - rp : rp) < r) cnt++;
    end
    return cnt;
  endfunction

  // R7/R8 window
  function automatic int exp_gate(input int lv);
    int g = 0;
    for (int j = 1; j <= N; j++) begin
      if (lv + j > N) g = g | (1 << (j - 1));
      else            g = g | (1 << (N + j - 1));
    end
    return g;
  endfunction

  // bench model of the registered state
  int m_phase, m_ref, m_ramp, m_div, m_lvl, m_mode;
  bit m_up;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_ref = HALF; m_ramp = 0; m_div = 0; m_lvl = 0; m_mode = 0; m_up = 1'b1;
    end else begin
      m_lvl   = exp_level(m_ref, m_ramp, m_mode);
      m_ref   = exp_ref(m_phase, int'(ma));
      m_phase = (m_phase + int'(step)) & ((1 << PH_W) - 1);
      if (m_div == int'(cdiv)) begin
        m_div = 0;
        if (m_ramp == 0) m_mode = int'(mode);
        if (m_up) begin
          if (m_ramp == TOP) begin m_up = 1'b0; m_ramp = TOP - 1; end
          else m_ramp++;
        end else begin
          if (m_ramp == 0) begin m_up = 1'b1; m_ramp = 1; end
          else m_ramp--;
        end
      end else begin
        m_div = (m_div + 1) & ((1 << DIV_W) - 1);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      string tag;
      if (m_mode != int'(mode)) tag = "R9 R6";
      else if (m_mode == 1)     tag = "R3 R6";
      else if (m_mode == 2)     tag = "R4 R6";
      else                      tag = "R2 R6 R1 R5";
      chk(int'(level) == m_lvl, tag, int'(level), m_lvl);
      chk(int'(gate) == exp_gate(m_lvl), "R7", int'(gate), exp_gate(m_lvl));
      chk($countones(gate) == N && gate[2*N-1:N] == ~gate[N-1:0], "R8",
          int'(gate), exp_gate(int'(level)));
      if (int'(level) > seen_max) seen_max = int'(level);
      if (int'(level) < seen_min) seen_min = int'(level);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(int'(level) == 0, "R10", int'(level), 0);
    chk(int'(gate) == exp_gate(0), "R10", int'(gate), exp_gate(0));
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R11: zero index pins the level at the midpoint in every mode
    step = 16'd311;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      repeat (300) @(negedge clk);
      chk(int'(level) == N / 2, "R11", int'(level), N / 2);
    end

    // full swing, fast carrier: both extreme levels must appear (R7)
    mode = 2'd0; ma = 8'd255; step = 16'd97; cdiv = '0;
    repeat (1500) @(negedge clk);
    chk(seen_max == N, "R7 top level", seen_max, N);
    chk(seen_min == 0, "R7 bottom level", seen_min, 0);

    // R9: mode request exactly on the valley tick and just after it
    for (int m = 1; m < 4; m++) begin
      cdiv = 8'(m - 1);
      while (!(m_ramp == 0 && m_div == int'(cdiv))) @(negedge clk);
      mode = 2'(m % 3);
      @(negedge clk);
      mode = 2'((m + 1) % 3);
      repeat (400) @(negedge clk);
    end

    // constrained random segments with mid-period mode changes
    for (int s = 0; s < 12; s++) begin
      mode = 2'($urandom_range(0, 3));
      ma   = 8'($urandom_range(0, 255));
      step = 16'($urandom_range(20, 400));
      cdiv = 8'($urandom_range(0, 3));
      repeat (int'($urandom_range(300, 900))) @(negedge clk);
      mode = 2'($urandom_range(0, 3));
      repeat (700) @(negedge clk);
    end

    chk_en = 1'b0;
    finish_run();
  end
endmodule